// File: doc/BRIEF.md
# Scanline Cache Fill Sequencer

This block is the fetch half of a video scan-out engine. It follows the horizontal and vertical pixel counters of a 640x480 raster that has 800 clocks per line. When the horizontal counter reaches the end of the visible area, it asks the memory arbiter for one burst transfer. The returned beats refill a one-line cache. Pixel output then reads that cache during the next line, and the fill uses only the horizontal blanking time.

A frame of fills begins on the line just before the first visible line and covers every visible line. It ends when the last visible line has been served. In half-height modes each cached line is shown twice, so fills happen only on odd lines. The number of 128-bit beats per fill depends on the display mode. The fetch address starts at the frame base and moves forward by one line of bytes after each fill. The sequencer reports when a fill is in progress and when it has completed.

Top module: `line_fill_seq`

## Requirements
- R1: A fill request is raised two clocks after the horizontal counter equals the visible width (640 by default) on a line where a fill is due.
- R2: A frame of fills starts on line V_TOTAL-1 (524) when `disp_mode[0]`=1 (full height) and on line V_TOTAL-2 (523) when `disp_mode[0]`=0 (half height). Before that line no fill is issued.
- R3: `mem_len` carries the number of beats minus one, decoded from `disp_mode[1:0]` as {depth, full}: 00 gives 19, 01 gives 39, 10 gives 39, 11 gives 79.
- R4: In full-height mode, after the start fill one fill is issued at the end of each line 0 to V_VIS-2. No fill is issued from line V_VIS-1 until the next start line.
- R5: In half-height mode, after the start fill fills are issued only at the end of odd lines below V_VIS-1.
- R6: While `video_en` is 0 no fill is issued. Clearing it mid-frame stops the remaining fills of that frame.
- R7: `mem_req` stays high until a cycle in which `mem_gnt` is high, and falls in the following cycle.
- R8: The first fill of a frame uses `frame_base` as its address. Each later fill uses the previous address plus (mem_len+1)*16 bytes.
- R9: Each beat with `beat_valid` is written one clock later through `lc_we`, with its data unchanged. `lc_addr` counts the beats of the fill from 0 to `mem_len`.
- R10: A change of `disp_mode` or `frame_base` after a frame's start fill does not alter the lengths or addresses of that frame's fills.
- R11: `fill_busy` is high from the request until the last beat. `fill_done` is low during a fill and is high once the last beat is taken. A fill started at a line end completes before the horizontal counter wraps.
- R12: During reset `mem_req`, `lc_we`, `fill_busy` and `fill_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| video_en | input | 1 | Enables fetching |
| disp_mode | input | 2 | Bit 0: full height/width; bit 1: 16 bpp |
| frame_base | input | ADDR_W | Byte address of the first line of the frame |
| hcount | input | CNT_W | Horizontal pixel counter |
| vcount | input | CNT_W | Vertical line counter |
| mem_req | output | 1 | Burst read request to the arbiter |
| mem_gnt | input | 1 | Grant from the arbiter |
| mem_addr | output | ADDR_W | Start byte address of the burst |
| mem_len | output | 7 | Beats in the burst minus one |
| beat_valid | input | 1 | Returned beat is valid |
| beat_data | input | DATA_W | Returned beat data |
| lc_we | output | 1 | Line cache write enable |
| lc_addr | output | 7 | Line cache write index |
| lc_wdata | output | DATA_W | Line cache write data |
| fill_busy | output | 1 | Fill in progress |
| fill_done | output | 1 | Last fill completed |

## Verification
The hardest case to reach is a mode or base change while a frame of fills is under way, combined with a slow arbiter. In that case the latched length and the running address must survive the change, and the late grant must still leave enough blanking for every beat. The bench shortens the raster through the counter parameters so that whole frames run quickly. It changes the mode and base on a middle line of some frames and clears the enable in the middle of another. Grant delays vary from fill to fill, and gaps are placed between beats. A scoreboard then checks the line, address and length of every request, and the index and data of every cache write.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  localparam int unsigned LEN_W = 7;

  typedef enum logic [1:0] {
    F_IDLE,
    F_REQ,
    F_BEAT
  } fetch_st_t;

  // {depth, full}: beats minus one per line fill
  function automatic logic [LEN_W-1:0] beats_minus_one(input logic [1:0] m);
    logic [LEN_W-1:0] r;
    unique case (m)
      2'b00:   r = 7'd19;
      2'b01:   r = 7'd39;
      2'b10:   r = 7'd39;
      default: r = 7'd79;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lfs_trigger.sv
module lfs_trigger
  import lfs_pkg::*;
#(
  parameter int H_VIS   = 640,
  parameter int V_VIS   = 480,
  parameter int V_TOTAL = 525,
  parameter int CNT_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             video_en,
  input  logic [1:0]       disp_mode,
  input  logic [CNT_W-1:0] hcount,
  input  logic [CNT_W-1:0] vcount,
  output logic             go_q,
  output logic             first_q,
  output logic [LEN_W-1:0] len_q
);

  localparam logic [CNT_W-1:0] LINE_END   = CNT_W'(H_VIS);
  localparam logic [CNT_W-1:0] START_FULL = CNT_W'(V_TOTAL - 1);
  localparam logic [CNT_W-1:0] START_HALF = CNT_W'(V_TOTAL - 2);
  localparam logic [CNT_W-1:0] LAST_VIS   = CNT_W'(V_VIS - 1);

  logic             full_q;
  logic             frame_on;
  logic             at_end;
  logic [CNT_W-1:0] start_line;

  assign at_end     = (hcount == LINE_END);
  assign start_line = full_q ? START_FULL : START_HALF;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q   <= 1'b0;
      len_q    <= beats_minus_one(2'b00);
      frame_on <= 1'b0;
      go_q     <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      go_q    <= 1'b0;
      first_q <= 1'b0;
      // mode-derived values freeze once a frame of fills is running
      if (!frame_on) begin
        full_q <= disp_mode[0];
        len_q  <= beats_minus_one(disp_mode);
      end
      if (!video_en) begin
        frame_on <= 1'b0;
      end else if (at_end) begin
        if (!frame_on && vcount == start_line) begin
          frame_on <= 1'b1;
          go_q     <= 1'b1;
          first_q  <= 1'b1;
        end else if (frame_on && vcount < LAST_VIS && (full_q || vcount[0])) begin
          go_q <= 1'b1;
        end else if (frame_on && vcount == LAST_VIS) begin
          frame_on <= 1'b0;
        end
      end
    end
  end

  // R1: fills are only launched from the line-end column
  a_r1_line_end: assert property (@(posedge clk) disable iff (rst)
    go_q |-> $past(hcount) == LINE_END);

  // R4: apart from the start fill, fills only serve visible lines
  a_r4_window: assert property (@(posedge clk) disable iff (rst)
    (go_q && !first_q) |-> $past(vcount) < LAST_VIS);

  // R6: disabled video launches nothing
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    !video_en |=> !go_q);

endmodule

// File: rtl/lfs_fetch.sv
module lfs_fetch
  import lfs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              first,
  input  logic [LEN_W-1:0]  len,
  input  logic [ADDR_W-1:0] frame_base,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  input  logic              beat_valid,
  input  logic [DATA_W-1:0] beat_data,
  output logic              lc_we,
  output logic [LEN_W-1:0]  lc_addr,
  output logic [DATA_W-1:0] lc_wdata,
  output logic              fill_busy,
  output logic              fill_done
);

  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int BYTE_SH    = $clog2(BEAT_BYTES);

  fetch_st_t         state;
  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] this_addr;
  logic [ADDR_W-1:0] line_bytes;
  logic [LEN_W-1:0]  beat_cnt;

  assign this_addr  = first ? frame_base : next_addr;
  assign line_bytes = (ADDR_W'(len) + ADDR_W'(1)) << BYTE_SH;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= F_IDLE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_len   <= '0;
      next_addr <= '0;
      beat_cnt  <= '0;
      lc_we     <= 1'b0;
      lc_addr   <= '0;
      lc_wdata  <= '0;
      fill_busy <= 1'b0;
      fill_done <= 1'b0;
    end else begin
      lc_we <= 1'b0;
      unique case (state)
        F_IDLE: begin
          if (go) begin
            state     <= F_REQ;
            mem_req   <= 1'b1;
            mem_addr  <= this_addr;
            mem_len   <= len;
            next_addr <= this_addr + line_bytes;
            fill_busy <= 1'b1;
            fill_done <= 1'b0;
          end
        end
        F_REQ: begin
          if (mem_gnt) begin
            state    <= F_BEAT;
            mem_req  <= 1'b0;
            beat_cnt <= '0;
          end
        end
        default: begin
          if (beat_valid) begin
            lc_we    <= 1'b1;
            lc_addr  <= beat_cnt;
            lc_wdata <= beat_data;
            beat_cnt <= beat_cnt + 1'b1;
            if (beat_cnt == mem_len) begin
              state     <= F_IDLE;
              fill_busy <= 1'b0;
              fill_done <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R7: request held until granted, then released
  a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> mem_req);
  a_r7_req_drop: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt) |=> !mem_req);

  // R9: cache writes follow returned beats and stay inside the burst
  a_r9_we_follows_beat: assert property (@(posedge clk) disable iff (rst)
    lc_we |-> $past(beat_valid));
  a_r9_addr_bound: assert property (@(posedge clk) disable iff (rst)
    lc_we |-> lc_addr <= mem_len);

  // R11: done and busy never overlap
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> !fill_busy);

endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
  import lfs_pkg::*;
#(
  parameter int H_VIS   = 640,
  parameter int V_VIS   = 480,
  parameter int V_TOTAL = 525,
  parameter int CNT_W   = 10,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              video_en,
  input  logic [1:0]        disp_mode,
  input  logic [ADDR_W-1:0] frame_base,
  input  logic [CNT_W-1:0]  hcount,
  input  logic [CNT_W-1:0]  vcount,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  input  logic              beat_valid,
  input  logic [DATA_W-1:0] beat_data,
  output logic              lc_we,
  output logic [LEN_W-1:0]  lc_addr,
  output logic [DATA_W-1:0] lc_wdata,
  output logic              fill_busy,
  output logic              fill_done
);

  logic             go;
  logic             first;
  logic [LEN_W-1:0] len;

  lfs_trigger #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .V_TOTAL(V_TOTAL), .CNT_W(CNT_W)
  ) trig_i (
    .clk(clk), .rst(rst), .video_en(video_en), .disp_mode(disp_mode),
    .hcount(hcount), .vcount(vcount),
    .go_q(go), .first_q(first), .len_q(len)
  );

  lfs_fetch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) fetch_i (
    .clk(clk), .rst(rst), .go(go), .first(first), .len(len),
    .frame_base(frame_base),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_len(mem_len),
    .beat_valid(beat_valid), .beat_data(beat_data),
    .lc_we(lc_we), .lc_addr(lc_addr), .lc_wdata(lc_wdata),
    .fill_busy(fill_busy), .fill_done(fill_done)
  );

endmodule

// File: tb/line_fill_seq_tb_top.sv
module line_fill_seq_tb_top;

  localparam int H_TOTAL = 240;
  localparam int H_VIS   = 100;
  localparam int V_VIS   = 20;
  localparam int V_TOTAL = 25;
  localparam int CNT_W   = 10;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              video_en = 1'b0;
  logic [1:0]        disp_mode = 2'b00;
  logic [ADDR_W-1:0] frame_base = '0;
  logic [CNT_W-1:0]  hcount = '0;
  logic [CNT_W-1:0]  vcount = '0;
  logic              mem_req, mem_gnt, beat_valid;
  logic [ADDR_W-1:0] mem_addr;
  logic [6:0]        mem_len, lc_addr;
  logic [DATA_W-1:0] beat_data, lc_wdata;
  logic              lc_we, fill_busy, fill_done;

  line_fill_seq #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .V_TOTAL(V_TOTAL), .CNT_W(CNT_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dut_i (
    .clk(clk), .rst(rst), .video_en(video_en), .disp_mode(disp_mode),
    .frame_base(frame_base), .hcount(hcount), .vcount(vcount),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_len(mem_len),
    .beat_valid(beat_valid), .beat_data(beat_data),
    .lc_we(lc_we), .lc_addr(lc_addr), .lc_wdata(lc_wdata),
    .fill_busy(fill_busy), .fill_done(fill_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int              q_line[$];
  logic [31:0]     q_addr[$];
  int              q_len[$];
  int              w_idx[$];
  logic [127:0]    w_dat[$];
  string           len_tag = "R3";
  string           line_tag = "R4";
  int              req_seen = 0;
  bit              pending = 1'b0;
  int              fill_num = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // R3 decode table: {depth, full}
  function automatic int exp_len(input logic [1:0] m);
    case (m)
      2'b00:   return 19;
      2'b01:   return 39;
      2'b10:   return 39;
      default: return 79;
    endcase
  endfunction

  task automatic wait_at(input int v, input int h);
    do @(negedge clk); while (!(vcount == CNT_W'(v) && hcount == CNT_W'(h)));
  endtask

  task automatic push_req(input int line, input logic [31:0] a, input int n);
    q_line.push_back(line);
    q_addr.push_back(a);
    q_len.push_back(n);
  endtask

  // raster model
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (hcount == CNT_W'(H_TOTAL - 1)) begin
        hcount = '0;
        vcount = (vcount == CNT_W'(V_TOTAL - 1)) ? '0 : vcount + 1'b1;
      end else begin
        hcount = hcount + 1'b1;
      end
    end
  end

  // arbiter and memory model
  initial begin
    mem_gnt = 1'b0;
    beat_valid = 1'b0;
    beat_data = '0;
    forever begin
      @(negedge clk);
      if (!rst && mem_req) begin
        int d;
        req_seen++;
        pending = 1'b1;
        check(hcount == CNT_W'(H_VIS + 2), "R1", "request column", hcount, H_VIS + 2);
        check(fill_busy && !fill_done, "R11", "busy/done at request",
              {fill_busy, fill_done}, 2);
        if (q_line.size() == 0) begin
          check(1'b0, "R6", "unexpected request on line", vcount, 0);
        end else begin
          int l;
          logic [31:0] a;
          int n;
          l = q_line.pop_front();
          a = q_addr.pop_front();
          n = q_len.pop_front();
          check(vcount == CNT_W'(l), (l >= V_VIS) ? "R2" : line_tag,
                "request line", vcount, l);
          check(mem_addr == a, (len_tag == "R10") ? "R10" : "R8",
                "request address", mem_addr, a);
          check(int'(mem_len) == n, len_tag, "burst length", mem_len, n);
        end
        d = (fill_num * 7) % 23;
        fill_num++;
        for (int i = 0; i < d; i++) begin
          @(negedge clk);
          check(mem_req == 1'b1, "R7", "request held before grant", mem_req, 1);
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        check(mem_req == 1'b0, "R7", "request dropped after grant", mem_req, 0);
        for (int i = 0; i <= int'(mem_len); i++) begin
          if (i % 9 == 4) @(negedge clk);
          beat_valid = 1'b1;
          beat_data = {mem_addr, 32'(i), 64'hA5A5_0000_0000_0000 ^ 64'(fill_num)};
          w_idx.push_back(i);
          w_dat.push_back(beat_data);
          @(negedge clk);
          beat_valid = 1'b0;
        end
      end
    end
  end

  // cache-write and completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && lc_we) begin
        if (w_idx.size() == 0) begin
          check(1'b0, "R9", "unexpected cache write", lc_addr, 0);
        end else begin
          int i;
          logic [127:0] dd;
          i = w_idx.pop_front();
          dd = w_dat.pop_front();
          check(int'(lc_addr) == i, "R9", "cache index", lc_addr, i);
          check(lc_wdata == dd, "R9", "cache data low", lc_wdata[63:0], dd[63:0]);
        end
      end
      if (!rst && pending && hcount == CNT_W'(H_TOTAL - 1)) begin
        check(fill_done && !fill_busy, "R11", "fill complete before wrap",
              {fill_busy, fill_done}, 1);
        pending = 1'b0;
      end
    end
  end

  task automatic do_frame(input logic [1:0] m, input logic [31:0] base,
                          input bit en, input int cut, input bit glitch);
    int k;
    int exp_n;
    int n;
    wait_at(V_VIS, 0);
    disp_mode = m;
    frame_base = base;
    video_en = en;
    req_seen = 0;
    len_tag = glitch ? "R10" : "R3";
    line_tag = m[0] ? "R4" : "R5";
    n = exp_len(m);
    exp_n = 0;
    k = 0;
    if (en) begin
      push_req(m[0] ? V_TOTAL - 1 : V_TOTAL - 2, base, n);
      exp_n++;
      k = 1;
      for (int v = 0; v < V_VIS - 1; v++) begin
        if ((m[0] || (v % 2 == 1)) && (cut == 0 || v < cut)) begin
          push_req(v, base + 32'(k * (n + 1) * 16), n);
          k++;
          exp_n++;
        end
      end
    end
    if (cut > 0) begin
      wait_at(cut, 0);
      video_en = 1'b0;
    end
    if (glitch) begin
      wait_at(5, 0);
      disp_mode = ~m;
      frame_base = base + 32'h4000;
    end
    wait_at(V_VIS - 1, H_TOTAL - 1);
    check(req_seen == exp_n, (!en || cut > 0) ? "R6" : line_tag,
          "fills in frame", req_seen, exp_n);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R12: reset state
    check(mem_req == 1'b0, "R12", "mem_req in reset", mem_req, 0);
    check(lc_we == 1'b0, "R12", "lc_we in reset", lc_we, 0);
    check(fill_busy == 1'b0, "R12", "fill_busy in reset", fill_busy, 0);
    check(fill_done == 1'b0, "R12", "fill_done in reset", fill_done, 0);
    rst = 1'b0;
    do_frame(2'b01, 32'h0001_0000, 1'b1, 0, 1'b0);
    do_frame(2'b11, 32'h0020_0000, 1'b1, 0, 1'b0);
    do_frame(2'b00, 32'h0003_0000, 1'b1, 0, 1'b0);
    do_frame(2'b10, 32'h0040_0000, 1'b1, 0, 1'b1);
    do_frame(2'b01, 32'h0005_0000, 1'b0, 0, 1'b0);
    do_frame(2'b11, 32'h0060_0000, 1'b1, 6, 1'b0);
    do_frame(2'b11, 32'h0070_0000, 1'b1, 0, 1'b1);
    video_en = 1'b0;
    repeat (300) @(negedge clk);
    check(q_line.size() == 0, "R4", "expected requests left", q_line.size(), 0);
    check(w_idx.size() == 0, "R9", "expected writes left", w_idx.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // watchdog
  initial begin
    repeat (120000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule